// File: doc/BRIEF.md
# Maximum-Likelihood Code-Group and Frame-Offset Search

This block finishes the second step of downlink cell acquisition. A frame has 15 slots. For each slot, an upstream correlator delivers 16 soft metrics, one for each of the 16 secondary-synchronisation codewords. The block holds these 240 values in a small metric store. A separate loadable table maps each (code group, slot) pair to the codeword that group sends in that slot.

When a start pulse arrives, the block visits every hypothesis (group, cyclic offset) in turn. For each one it sums 15 metrics picked through the table and keeps only the largest sum seen so far. It then reports the winning group, the frame offset and the winning score together with a one-cycle done pulse.

No per-hypothesis score is ever stored. The search streams one metric per clock through a short read pipeline into a single accumulator and comparator. A full search therefore costs one clock per addition, and nothing is spent on holding the 960-entry hypothesis matrix.

Top module: `ml_group_search`

## Requirements
- R1: Metric store. A write with `met_we` high stores the signed `MET_W`-bit value `met_val` at codeword field `met_cw` (0..15, standing for codewords 1..16) and slot `met_slot` (0..14). Writing the same location again replaces the old value, and a search uses the latest value.
- R2: Codebook table. A write with `cb_we` high sets the entry for group `cb_grp`, slot `cb_slot` (0..14) to codeword field `cb_cw` (0..15). A search uses the entries as they stand when it starts.
- R3: The score of group i at offset j is the sum over m=0..14 of S[cw(i,(m+j) mod 15)][m]. It is computed in `MET_W+4` signed bits, so fifteen copies of the most positive or most negative metric give the exact sum.
- R4: The block reports on `grp_o`, `off_o` and `score_o` the group, offset and score of the largest score over all `N_GRP` x 15 hypotheses. `grp_o` is always below `N_GRP` and `off_o` is always below 15.
- R5: On equal scores, the lowest group wins, and within that group the lowest offset wins.
- R6: A `start` pulse sampled while the block is idle begins a search. `done` is high for exactly one cycle, on the `N_GRP*225+3`-th rising edge after the edge that sampled `start`.
- R7: `busy` is high from the edge that samples an accepted `start` until the edge that raises `done`, and it is low in the `done` cycle. A `start` pulse sampled while `busy` is high has no effect.
- R8: After reset, `busy`, `done`, `grp_o`, `off_o` and `score_o` are all zero. The result outputs change only on the edge that raises `done` and hold their value until the next one.
- R9: Metrics are two's complement. A search over all-negative metrics returns the least negative sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| met_we | input | 1 | Metric write strobe |
| met_cw | input | 4 | Codeword field of metric write (0..15) |
| met_slot | input | 4 | Slot of metric write (0..14) |
| met_val | input | MET_W | Signed metric value |
| cb_we | input | 1 | Codebook write strobe |
| cb_grp | input | GRP_W | Group of codebook write |
| cb_slot | input | 4 | Slot of codebook write (0..14) |
| cb_cw | input | 4 | Codeword field stored (0..15) |
| start | input | 1 | Search start pulse |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| grp_o | output | GRP_W | Winning code group |
| off_o | output | 4 | Winning frame offset (0..14) |
| score_o | output | MET_W+4 | Winning score, signed |

## Verification
The bench builds the block with `N_GRP=8` and `MET_W=8`. That makes a full search 1803 cycles, so a dozen complete searches fit easily, each one compared against an exhaustive arithmetic maximum over all 120 hypotheses computed in the bench. The narrow metric width puts the extreme values +127 and -128 within reach, and fifteen of either fill the 12-bit score, which exercises the overflow margin directly. Flat metric matrices force every hypothesis to tie, which pins down the tie-breaking order. Planting a strong pattern for each of the eight groups in turn, at a different offset each time, covers every group index.

// File: rtl/ml_srch_pkg.sv
package ml_srch_pkg;
  localparam int SLOTS    = 15;
  localparam int CWS      = 16;
  localparam int SLOT_W   = 4;
  localparam int CW_W     = 4;
  localparam int GUARD_W  = 4;

  // (a + b) mod 15 for a, b in 0..14
  function automatic logic [SLOT_W-1:0] slot_wrap(input logic [SLOT_W-1:0] a,
                                                  input logic [SLOT_W-1:0] b);
    logic [SLOT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (SLOT_W+1)'(SLOTS)) return SLOT_W'(s - (SLOT_W+1)'(SLOTS));
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/ml_sdp_ram.sv
module ml_sdp_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ml_hyp_seq.sv
module ml_hyp_seq
  import ml_srch_pkg::*;
#(
  parameter int N_GRP = 64,
  parameter int GRP_W = $clog2(N_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  output logic              run,
  output logic [GRP_W-1:0]  grp,
  output logic [SLOT_W-1:0] off,
  output logic [SLOT_W-1:0] term,
  output logic [SLOT_W-1:0] tab_slot,
  output logic              first,
  output logic              last,
  output logic              fin
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(N_GRP - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      grp  <= '0;
      off  <= '0;
      term <= '0;
    end else if (launch) begin
      run  <= 1'b1;
      grp  <= '0;
      off  <= '0;
      term <= '0;
    end else if (run) begin
      if (term == LAST_SLOT) begin
        term <= '0;
        if (off == LAST_SLOT) begin
          off <= '0;
          if (grp == LAST_GRP) begin
            grp <= '0;
            run <= 1'b0;
          end else begin
            grp <= grp + 1'b1;
          end
        end else begin
          off <= off + 1'b1;
        end
      end else begin
        term <= term + 1'b1;
      end
    end
  end

  always_comb begin
    tab_slot = slot_wrap(term, off);
    first    = (term == '0);
    last     = (term == LAST_SLOT);
    fin      = last && (off == LAST_SLOT) && (grp == LAST_GRP);
  end
endmodule

// File: rtl/ml_score_max.sv
module ml_score_max
  import ml_srch_pkg::*;
#(
  parameter int MET_W = 12,
  parameter int GRP_W = 6,
  parameter int SUM_W = MET_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              first,
  input  logic              last,
  input  logic              fin,
  input  logic [GRP_W-1:0]  grp,
  input  logic [SLOT_W-1:0] off,
  input  logic [MET_W-1:0]  met,
  output logic              pend,
  output logic              done,
  output logic [GRP_W-1:0]  grp_o,
  output logic [SLOT_W-1:0] off_o,
  output logic [SUM_W-1:0]  score_o
);
  logic [SUM_W-1:0]  met_ext;
  logic [SUM_W-1:0]  acc;
  logic              a_last, a_fin;
  logic [GRP_W-1:0]  a_grp;
  logic [SLOT_W-1:0] a_off;
  logic              have;
  logic [SUM_W-1:0]  best;
  logic [GRP_W-1:0]  best_grp;
  logic [SLOT_W-1:0] best_off;
  logic              better;

  assign met_ext = {{GUARD_W{met[MET_W-1]}}, met};

  // stage A: running sum of one hypothesis
  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      a_last <= 1'b0;
      a_fin  <= 1'b0;
      a_grp  <= '0;
      a_off  <= '0;
      acc    <= '0;
    end else begin
      pend   <= vld;
      a_last <= vld && last;
      a_fin  <= vld && fin;
      if (vld) begin
        a_grp <= grp;
        a_off <= off;
        acc   <= first ? met_ext : acc + met_ext;
      end
    end
  end

  // strict greater keeps the earlier hypothesis on ties
  assign better = !have || ($signed(acc) > $signed(best));

  // stage B: running maximum and registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      have     <= 1'b0;
      best     <= '0;
      best_grp <= '0;
      best_off <= '0;
      done     <= 1'b0;
      grp_o    <= '0;
      off_o    <= '0;
      score_o  <= '0;
    end else begin
      done <= 1'b0;
      if (pend && a_last) begin
        if (a_fin) begin
          have    <= 1'b0;
          done    <= 1'b1;
          grp_o   <= better ? a_grp : best_grp;
          off_o   <= better ? a_off : best_off;
          score_o <= better ? acc   : best;
        end else if (better) begin
          have     <= 1'b1;
          best     <= acc;
          best_grp <= a_grp;
          best_off <= a_off;
        end
      end
    end
  end
endmodule

// File: rtl/ml_group_search.sv
module ml_group_search
  import ml_srch_pkg::*;
#(
  parameter int N_GRP = 64,
  parameter int MET_W = 12,
  parameter int GRP_W = $clog2(N_GRP),
  parameter int SUM_W = MET_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              met_we,
  input  logic [CW_W-1:0]   met_cw,
  input  logic [SLOT_W-1:0] met_slot,
  input  logic [MET_W-1:0]  met_val,
  input  logic              cb_we,
  input  logic [GRP_W-1:0]  cb_grp,
  input  logic [SLOT_W-1:0] cb_slot,
  input  logic [CW_W-1:0]   cb_cw,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [GRP_W-1:0]  grp_o,
  output logic [SLOT_W-1:0] off_o,
  output logic [SUM_W-1:0]  score_o
);
  localparam int CB_AW  = GRP_W + SLOT_W;
  localparam int MET_AW = CW_W + SLOT_W;

  logic              launch;
  logic              s_run, s_first, s_last, s_fin;
  logic [GRP_W-1:0]  s_grp;
  logic [SLOT_W-1:0] s_off, s_term, s_tab;

  logic              p1_vld, p1_first, p1_last, p1_fin;
  logic [GRP_W-1:0]  p1_grp;
  logic [SLOT_W-1:0] p1_off, p1_term;
  logic              p2_vld, p2_first, p2_last, p2_fin;
  logic [GRP_W-1:0]  p2_grp;
  logic [SLOT_W-1:0] p2_off;

  logic [CW_W-1:0]   cw_q;
  logic [MET_W-1:0]  met_q;
  logic              pend;

  assign busy   = s_run | p1_vld | p2_vld | pend;
  assign launch = start & ~busy;

  ml_hyp_seq #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .run(s_run), .grp(s_grp), .off(s_off), .term(s_term), .tab_slot(s_tab),
    .first(s_first), .last(s_last), .fin(s_fin)
  );

  ml_sdp_ram #(.DW(CW_W), .AW(CB_AW)) u_cbook (
    .clk(clk), .we(cb_we), .waddr({cb_grp, cb_slot}), .wdata(cb_cw),
    .raddr({s_grp, s_tab}), .rdata(cw_q)
  );

  ml_sdp_ram #(.DW(MET_W), .AW(MET_AW)) u_mstore (
    .clk(clk), .we(met_we), .waddr({met_cw, met_slot}), .wdata(met_val),
    .raddr({cw_q, p1_term}), .rdata(met_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_vld <= 1'b0; p1_first <= 1'b0; p1_last <= 1'b0; p1_fin <= 1'b0;
      p1_grp <= '0;   p1_off   <= '0;   p1_term <= '0;
      p2_vld <= 1'b0; p2_first <= 1'b0; p2_last <= 1'b0; p2_fin <= 1'b0;
      p2_grp <= '0;   p2_off   <= '0;
    end else begin
      p1_vld   <= s_run;
      p1_first <= s_first;
      p1_last  <= s_last;
      p1_fin   <= s_fin;
      p1_grp   <= s_grp;
      p1_off   <= s_off;
      p1_term  <= s_term;
      p2_vld   <= p1_vld;
      p2_first <= p1_first;
      p2_last  <= p1_last;
      p2_fin   <= p1_fin;
      p2_grp   <= p1_grp;
      p2_off   <= p1_off;
    end
  end

  ml_score_max #(.MET_W(MET_W), .GRP_W(GRP_W), .SUM_W(SUM_W)) u_max (
    .clk(clk), .rst(rst),
    .vld(p2_vld), .first(p2_first), .last(p2_last), .fin(p2_fin),
    .grp(p2_grp), .off(p2_off), .met(met_q),
    .pend(pend), .done(done), .grp_o(grp_o), .off_o(off_o), .score_o(score_o)
  );
endmodule

// File: rtl/ml_group_search_chk.sv
module ml_group_search_chk
  import ml_srch_pkg::*;
#(
  parameter int N_GRP = 64,
  parameter int MET_W = 12,
  parameter int GRP_W = $clog2(N_GRP),
  parameter int SUM_W = MET_W + GUARD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [GRP_W-1:0]  grp_o,
  input logic [SLOT_W-1:0] off_o,
  input logic [SUM_W-1:0]  score_o
);
  localparam int LAT   = N_GRP * SLOTS * SLOTS + 3;
  localparam int S_MAX = SLOTS * ((2 ** (MET_W-1)) - 1);
  localparam int S_MIN = -SLOTS * (2 ** (MET_W-1));

  int unsigned since;
  always_ff @(posedge clk) begin
    if (rst)                 since <= 0;
    else if (start && !busy) since <= 0;
    else if (since < LAT+8)  since <= since + 1;
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> since == LAT);
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_range_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(grp_o) < N_GRP) && (int'(off_o) < SLOTS));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed(score_o) <= S_MAX) && ($signed(score_o) >= S_MIN));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(grp_o) && $stable(off_o) && $stable(score_o));
endmodule

bind ml_group_search ml_group_search_chk #(
  .N_GRP(N_GRP), .MET_W(MET_W), .GRP_W(GRP_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .grp_o(grp_o), .off_o(off_o), .score_o(score_o)
);

// File: tb/test_ml_group_search.sv
module test_ml_group_search;
  localparam int NG    = 8;
  localparam int MW    = 8;
  localparam int GW    = 3;
  localparam int SW    = MW + 4;
  localparam int LAT   = NG * 225 + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          met_we = 1'b0;
  logic [3:0]    met_cw = '0;
  logic [3:0]    met_slot = '0;
  logic [MW-1:0] met_val = '0;
  logic          cb_we = 1'b0;
  logic [GW-1:0] cb_grp = '0;
  logic [3:0]    cb_slot = '0;
  logic [3:0]    cb_cw = '0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [GW-1:0] grp_o;
  logic [3:0]    off_o;
  logic [SW-1:0] score_o;

  always #2 clk = ~clk;

  ml_group_search #(.N_GRP(NG), .MET_W(MW)) i_ml_group_search (
    .clk(clk), .rst(rst), .met_we(met_we), .met_cw(met_cw), .met_slot(met_slot),
    .met_val(met_val), .cb_we(cb_we), .cb_grp(cb_grp), .cb_slot(cb_slot),
    .cb_cw(cb_cw), .start(start), .busy(busy), .done(done), .grp_o(grp_o),
    .off_o(off_o), .score_o(score_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cbk [NG][15];
  int mtx [16][15];
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd(int span);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[30:8] % span);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cb(int g, int s, int c);
    @(negedge clk);
    cb_we = 1'b1; cb_grp = GW'(g); cb_slot = 4'(s); cb_cw = 4'(c);
    cbk[g][s] = c;
    @(negedge clk);
    cb_we = 1'b0;
  endtask

  task automatic push_matrix();
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 15; s++) begin
        @(negedge clk);
        met_we = 1'b1; met_cw = 4'(c); met_slot = 4'(s); met_val = MW'(mtx[c][s]);
      end
    @(negedge clk);
    met_we = 1'b0;
  endtask

  task automatic fill_const(int v);
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 15; s++) mtx[c][s] = v;
  endtask

  task automatic fill_rand(int lo, int span);
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 15; s++) mtx[c][s] = lo + rnd(span);
  endtask

  task automatic plant(int g, int off, int boost);
    for (int m = 0; m < 15; m++) mtx[cbk[g][(m + off) % 15]][m] += boost;
  endtask

  // exhaustive model: strict greater keeps earliest hypothesis
  task automatic model(output int bg, output int bo, output int bs);
    bg = 0; bo = 0; bs = 0;
    for (int g = 0; g < NG; g++)
      for (int j = 0; j < 15; j++) begin
        int sum = 0;
        for (int m = 0; m < 15; m++) sum += mtx[cbk[g][(m + j) % 15]][m];
        if ((g == 0 && j == 0) || sum > bs) begin bg = g; bo = j; bs = sum; end
      end
  endtask

  task automatic search(string req, bit poke);
    int eg, eo, es, cyc, busy_bad, hg, ho, hs;
    model(eg, eo, es);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0; busy_bad = 0;
    while (!done && cyc < LAT + 20) begin
      if (!busy) busy_bad++;
      if (poke && cyc == 300) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk("R6", "done latency", cyc, LAT);
    chk("R7", "busy gaps during search", busy_bad, 0);
    chk("R7", "busy in done cycle", int'(busy), 0);
    chk(req, "group", int'(grp_o), eg);
    chk(req, "offset", int'(off_o), eo);
    chk(req, "score", int'($signed(score_o)), es);
    hg = int'(grp_o); ho = int'(off_o); hs = int'($signed(score_o));
    repeat (4) @(negedge clk);
    chk("R6", "done width", int'(done), 0);
    chk("R8", "result hold", int'(grp_o)*1000000 + int'(off_o)*10000 + int'($signed(score_o)),
        hg*1000000 + ho*10000 + hs);
  endtask

  initial begin
    repeat (LAT * 40 + 30000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "reset busy", int'(busy), 0);
    chk("R8", "reset done", int'(done), 0);
    chk("R8", "reset group", int'(grp_o), 0);
    chk("R8", "reset offset", int'(off_o), 0);
    chk("R8", "reset score", int'(score_o), 0);

    // R2: random codebook load
    for (int g = 0; g < NG; g++)
      for (int s = 0; s < 15; s++) wr_cb(g, s, rnd(16));

    // R4: planted hypothesis for every group
    for (int g = 0; g < NG; g++) begin
      fill_rand(0, 16);
      plant(g, (3 * g + 1) % 15, 60);
      push_matrix();
      search("R4", 1'b0);
    end

    // R5: all hypotheses tie
    fill_const(5);
    push_matrix();
    search("R5", 1'b0);
    chk("R5", "tie keeps group 0 offset 0", int'(grp_o) * 100 + int'(off_o), 0);

    // R9 and R5: flat negative
    fill_const(-3);
    push_matrix();
    search("R9", 1'b0);
    chk("R9", "flat negative score", int'($signed(score_o)), -45);

    // R3: extremes
    fill_const(127);
    push_matrix();
    search("R3", 1'b0);
    chk("R3", "max positive sum", int'($signed(score_o)), 1905);
    fill_const(-128);
    push_matrix();
    search("R3", 1'b0);
    chk("R3", "max negative sum", int'($signed(score_o)), -1920);

    // R9: random negative metrics
    fill_rand(-100, 100);
    push_matrix();
    search("R9", 1'b0);

    // R1: overwrite the store with a new planted pattern
    fill_rand(0, 16);
    push_matrix();
    plant(6, 13, 50);
    push_matrix();
    search("R1", 1'b0);

    // R2: reload one group's row, plant on it
    for (int s = 0; s < 15; s++) wr_cb(5, s, rnd(16));
    fill_rand(0, 16);
    plant(5, 9, 70);
    push_matrix();
    search("R2", 1'b0);

    // R7: extra start pulse mid-search is ignored
    fill_rand(-20, 40);
    plant(2, 14, 40);
    push_matrix();
    search("R7", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule